// File: doc/BRIEF.md
# Navigation Sentence Field Extractor

This block sits on the serial line of a satellite navigation receiver and turns the raw character stream into a stream of sentence fields. A built-in asynchronous receiver uses 16x oversampling. It recovers 8N1 characters at a rate set by a clock-divider parameter. At 50 MHz the default divider gives 4800 bit/s. A framer then follows the sentence structure. It waits for the `$` start marker. It splits the body at every comma, so empty fields count as fields too. It closes the sentence on carriage return followed by line feed.

Each body character appears on a valid strobe together with the index of the field it belongs to. A separate strobe marks the end of each field. If the sentence carries a `*hh` trailer, the block checks it against a running XOR of the body. It reports a pass or fail pulse in the same cycle as the end-of-sentence pulse.

Error pulses report four cases: a sentence cut short by a fresh `$`, a bad terminator, an over-long sentence, and a character whose stop bit was low. Downstream logic that decodes positions or times consumes the field stream directly and never has to handle raw bytes.

Top module: `nmea_field_extractor`

## Requirements
- R1: The receiver takes characters as 8 data bits, LSB first, no parity, one stop bit. One bit lasts 16 oversample ticks, and one tick lasts OVS_DIV clocks. A falling edge is accepted as a start bit only if the line is still low 8 ticks later. A low pulse shorter than that produces no character.
- R2: A character whose stop bit is sampled low raises `err_frame_o` for one cycle and produces no character. Any sentence in progress is dropped, and later characters are ignored until the next `$` (0x24).
- R3: While no sentence is open, every character other than `$` is ignored. No field, end or sentence strobe results.
- R4: Every character after `$` other than `,` (0x2C), `*` (0x2A) and CR (0x0D) is presented once on `fld_valid_o`, with `fld_char_o` and `fld_idx_o`. The first field after `$` has index 0. `fld_valid_o` and `fld_end_o` are never high in the same cycle.
- R5: Each `,` pulses `fld_end_o` with `fld_idx_o` equal to the index of the field it closes. The next field's index is one higher. An empty field between two commas still gets its own end pulse.
- R6: A `*` or a CR also pulses `fld_end_o` for the field in progress, so the last field of a sentence is always closed.
- R7: A CR followed directly by LF (0x0A) pulses `sent_end_o` for one cycle, and the framer then waits for the next `$`.
- R8: The checksum is the XOR of all characters strictly between `$` and `*`. After `*` exactly two hex digits (0-9, A-F or a-f, high nibble first) are expected. If `*` was present, then with `sent_end_o` exactly one of `cks_ok_o` or `cks_bad_o` pulses. `cks_bad_o` is used for a mismatch and for anything other than two hex digits. If `*` was absent, neither pulses.
- R9: A `$` inside an open sentence pulses `err_abort_o` and starts a new sentence, whose field index begins again at 0.
- R10: Any character other than LF directly after the CR pulses `err_abort_o` and closes the sentence without `sent_end_o`.
- R11: A sentence may hold at most MAX_LEN (82) characters, counting from `$` through LF. A further character pulses `err_ovf_o`, discards the sentence, and suppresses all output until the next `$`.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from the receiver, idle high |
| fld_valid_o | output | 1 | A field character is on `fld_char_o` |
| fld_char_o | output | 8 | Field character |
| fld_idx_o | output | $clog2(MAX_LEN+1) | Index of the field for the current character or field end |
| fld_end_o | output | 1 | The field with index `fld_idx_o` is complete |
| sent_end_o | output | 1 | Sentence closed by CR LF |
| cks_ok_o | output | 1 | Trailer matched the XOR, with `sent_end_o` |
| cks_bad_o | output | 1 | Trailer mismatched or malformed, with `sent_end_o` |
| err_abort_o | output | 1 | Sentence cut by `$` or by a bad terminator |
| err_ovf_o | output | 1 | Sentence longer than MAX_LEN |
| err_frame_o | output | 1 | Stop bit sampled low |

## Verification
The hardest conditions to reach from the ports are the length guard and the framing error. The length limit can only be reached by streaming a full-length sentence. The bench sends one sentence of exactly 82 characters, which must complete normally. It then sends one with two more body characters, where the CR becomes the 83rd character and must trigger the overflow instead of closing the sentence. For the framing error, the bench drives a character with its stop bit held low in the middle of an open sentence. It then checks that the rest of that sentence produces nothing. A short low glitch follows, to confirm that the midpoint qualification of the start bit rejects it.

// File: rtl/nmea_pkg.sv
package nmea_pkg;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_COMMA  = 8'h2C;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_BREAK = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        FR_HUNT  = 2'd0,
        FR_BODY  = 2'd1,
        FR_CKSUM = 2'd2,
        FR_WAITL = 2'd3
    } fr_state_e;

    // {is_hex, nibble}
    function automatic logic [4:0] hex_value(input logic [7:0] c);
        if (c >= 8'h30 && c <= 8'h39)
            return {1'b1, c[3:0]};
        else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
            return {1'b1, 4'(c[3:0] + 4'd9)};
        else
            return 5'd0;
    endfunction

endpackage

// File: rtl/nmea_uart_rx.sv
module nmea_uart_rx
    import nmea_pkg::*;
#(
    parameter int OVS_DIV = 651
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       frame_err_o
);

    localparam int DIV_W = $clog2(OVS_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OVS_DIV - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [DIV_W-1:0] div;
        logic [3:0]       tick;
        logic [2:0]       nbit;
        logic [7:0]       sh;
        logic [1:0]       sync;
        logic [7:0]       dat;
        logic             vld;
        logic             ferr;
    } rx_reg_t;

    rx_reg_t q, n;
    logic    line;
    logic    tick_now;

    assign line     = q.sync[1];
    assign tick_now = (q.div == DIV_LAST);

    always_comb begin
        n      = q;
        n.sync = {q.sync[0], rx_i};
        n.vld  = 1'b0;
        n.ferr = 1'b0;
        if (q.st != RX_IDLE && q.st != RX_BREAK)
            n.div = tick_now ? '0 : q.div + 1'b1;
        unique case (q.st)
            RX_IDLE: begin
                n.div  = '0;
                n.tick = '0;
                if (!line) n.st = RX_START;
            end
            RX_START: if (tick_now) begin
                n.tick = q.tick + 1'b1;
                if (q.tick == 4'd7) begin
                    n.tick = '0;
                    n.nbit = '0;
                    n.st   = line ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: if (tick_now) begin
                n.tick = q.tick + 1'b1;
                if (q.tick == 4'd15) begin
                    n.sh   = {line, q.sh[7:1]};
                    n.nbit = q.nbit + 1'b1;
                    if (q.nbit == 3'd7) n.st = RX_STOP;
                end
            end
            RX_STOP: if (tick_now) begin
                n.tick = q.tick + 1'b1;
                if (q.tick == 4'd15) begin
                    if (line) begin
                        n.vld = 1'b1;
                        n.dat = q.sh;
                        n.st  = RX_IDLE;
                    end else begin
                        n.ferr = 1'b1;
                        n.st   = RX_BREAK;
                    end
                end
            end
            RX_BREAK: if (line) n.st = RX_IDLE;
            default: n.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= n;
        end
    end

    assign byte_vld_o  = q.vld;
    assign byte_o      = q.dat;
    assign frame_err_o = q.ferr;

endmodule

// File: rtl/nmea_framer.sv
module nmea_framer
    import nmea_pkg::*;
#(
    parameter int MAX_LEN = 82
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            byte_vld_i,
    input  logic [7:0]                      byte_i,
    input  logic                            frame_err_i,
    output logic                            fld_valid_o,
    output logic [7:0]                      fld_char_o,
    output logic [$clog2(MAX_LEN+1)-1:0]    fld_idx_o,
    output logic                            fld_end_o,
    output logic                            sent_end_o,
    output logic                            cks_ok_o,
    output logic                            cks_bad_o,
    output logic                            err_abort_o,
    output logic                            err_ovf_o,
    output logic                            err_frame_o
);

    localparam int CNT_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        fr_state_e        st;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] idx;
        logic [7:0]       cx;
        logic [1:0]       hcnt;
        logic [7:0]       hval;
        logic             star;
        logic             malf;
        logic             fv;
        logic [7:0]       fch;
        logic [CNT_W-1:0] fidx;
        logic             fend;
        logic             send;
        logic             cok;
        logic             cbad;
        logic             abort;
        logic             ovf;
        logic             ferr;
    } fr_reg_t;

    fr_reg_t    q, n;
    logic [4:0] hv;
    logic       cks_match;

    assign hv        = hex_value(byte_i);
    assign cks_match = !q.malf && (q.hcnt == 2'd2) && (q.hval == q.cx);

    always_comb begin
        n       = q;
        n.fv    = 1'b0;
        n.fend  = 1'b0;
        n.send  = 1'b0;
        n.cok   = 1'b0;
        n.cbad  = 1'b0;
        n.abort = 1'b0;
        n.ovf   = 1'b0;
        n.ferr  = 1'b0;
        if (frame_err_i) begin
            n.ferr = 1'b1;
            n.st   = FR_HUNT;
        end else if (byte_vld_i) begin
            if (byte_i == CH_DOLLAR) begin
                n.abort = (q.st != FR_HUNT);
                n.st    = FR_BODY;
                n.len   = CNT_W'(1);
                n.idx   = '0;
                n.cx    = '0;
                n.hcnt  = '0;
                n.hval  = '0;
                n.star  = 1'b0;
                n.malf  = 1'b0;
            end else if (q.st == FR_HUNT) begin
                n.st = FR_HUNT;
            end else if (q.len == CNT_W'(MAX_LEN)) begin
                n.ovf = 1'b1;
                n.st  = FR_HUNT;
            end else begin
                n.len = q.len + 1'b1;
                unique case (q.st)
                    FR_BODY: begin
                        if (byte_i == CH_COMMA) begin
                            n.fend = 1'b1;
                            n.fidx = q.idx;
                            n.idx  = q.idx + 1'b1;
                            n.cx   = q.cx ^ byte_i;
                        end else if (byte_i == CH_STAR) begin
                            n.fend = 1'b1;
                            n.fidx = q.idx;
                            n.star = 1'b1;
                            n.st   = FR_CKSUM;
                        end else if (byte_i == CH_CR) begin
                            n.fend = 1'b1;
                            n.fidx = q.idx;
                            n.st   = FR_WAITL;
                        end else begin
                            n.fv   = 1'b1;
                            n.fch  = byte_i;
                            n.fidx = q.idx;
                            n.cx   = q.cx ^ byte_i;
                        end
                    end
                    FR_CKSUM: begin
                        if (byte_i == CH_CR) begin
                            n.st = FR_WAITL;
                        end else if (hv[4] && q.hcnt != 2'd2) begin
                            n.hval = {q.hval[3:0], hv[3:0]};
                            n.hcnt = q.hcnt + 1'b1;
                        end else begin
                            n.malf = 1'b1;
                        end
                    end
                    FR_WAITL: begin
                        n.st = FR_HUNT;
                        if (byte_i == CH_LF) begin
                            n.send = 1'b1;
                            n.cok  = q.star && cks_match;
                            n.cbad = q.star && !cks_match;
                        end else begin
                            n.abort = 1'b1;
                        end
                    end
                    default: n.st = FR_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign fld_valid_o = q.fv;
    assign fld_char_o  = q.fch;
    assign fld_idx_o   = q.fidx;
    assign fld_end_o   = q.fend;
    assign sent_end_o  = q.send;
    assign cks_ok_o    = q.cok;
    assign cks_bad_o   = q.cbad;
    assign err_abort_o = q.abort;
    assign err_ovf_o   = q.ovf;
    assign err_frame_o = q.ferr;

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FR_HUNT && $past(q.st) == FR_HUNT)
            |-> !(fld_valid_o || fld_end_o || sent_end_o)); // R3

    AST_CKS_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cks_ok_o || cks_bad_o) |-> (sent_end_o && $past(q.st) == FR_WAITL)); // R8

    AST_CKS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cks_ok_o && cks_bad_o)); // R8

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != FR_HUNT) |-> (q.len <= CNT_W'(MAX_LEN))); // R11

    AST_RESTART_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (err_abort_o && q.st == FR_BODY) |-> (q.idx == '0 && q.len == CNT_W'(1))); // R9

endmodule

// File: rtl/nmea_field_extractor.sv
module nmea_field_extractor
    import nmea_pkg::*;
#(
    parameter int OVS_DIV = 651,
    parameter int MAX_LEN = 82
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_i,
    output logic                          fld_valid_o,
    output logic [7:0]                    fld_char_o,
    output logic [$clog2(MAX_LEN+1)-1:0]  fld_idx_o,
    output logic                          fld_end_o,
    output logic                          sent_end_o,
    output logic                          cks_ok_o,
    output logic                          cks_bad_o,
    output logic                          err_abort_o,
    output logic                          err_ovf_o,
    output logic                          err_frame_o
);

    logic       byte_vld;
    logic [7:0] byte_dat;
    logic       frame_err;

    nmea_uart_rx #(.OVS_DIV(OVS_DIV)) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx_i),
        .byte_vld_o  (byte_vld),
        .byte_o      (byte_dat),
        .frame_err_o (frame_err)
    );

    nmea_framer #(.MAX_LEN(MAX_LEN)) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld_i  (byte_vld),
        .byte_i      (byte_dat),
        .frame_err_i (frame_err),
        .fld_valid_o (fld_valid_o),
        .fld_char_o  (fld_char_o),
        .fld_idx_o   (fld_idx_o),
        .fld_end_o   (fld_end_o),
        .sent_end_o  (sent_end_o),
        .cks_ok_o    (cks_ok_o),
        .cks_bad_o   (cks_bad_o),
        .err_abort_o (err_abort_o),
        .err_ovf_o   (err_ovf_o),
        .err_frame_o (err_frame_o)
    );

    AST_CHAR_NOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(fld_valid_o && fld_end_o)); // R4

    AST_BYTE_OR_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_err)); // R2

    AST_FERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_err) |-> !(fld_valid_o || fld_end_o || sent_end_o)); // R2

    AST_OUTCOME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sent_end_o, err_ovf_o, err_frame_o})); // R7

endmodule

// File: tb/test_nmea_field_extractor.sv
module test_nmea_field_extractor;

    localparam int OVS  = 2;
    localparam int MAXL = 82;
    localparam int BIT  = 16 * OVS;
    localparam int IW   = $clog2(MAXL + 1);
    localparam int WD   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          fld_valid, fld_end, sent_end, cks_ok, cks_bad;
    logic          err_abort, err_ovf, err_frame;
    logic [7:0]    fld_char;
    logic [IW-1:0] fld_idx;

    always #10 clk = ~clk;

    nmea_field_extractor #(.OVS_DIV(OVS), .MAX_LEN(MAXL)) i_nmea_field_extractor (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .fld_valid_o(fld_valid), .fld_char_o(fld_char), .fld_idx_o(fld_idx),
        .fld_end_o(fld_end), .sent_end_o(sent_end), .cks_ok_o(cks_ok),
        .cks_bad_o(cks_bad), .err_abort_o(err_abort), .err_ovf_o(err_ovf),
        .err_frame_o(err_frame)
    );

    // recorder
    logic   clr_req = 1'b0;
    string  rec;
    int     n_end, idx_bad, n_sent, n_ok, n_bad, n_abort, n_ovf, n_frame, after_ovf, exp_idx;

    always @(negedge clk) begin
        if (clr_req) begin
            rec = ""; n_end = 0; idx_bad = 0; n_sent = 0; n_ok = 0; n_bad = 0;
            n_abort = 0; n_ovf = 0; n_frame = 0; after_ovf = 0; exp_idx = 0;
        end else if (rst_n) begin
            if (fld_valid) begin
                rec = $sformatf("%s%c", rec, fld_char);
                if (int'(fld_idx) != exp_idx) idx_bad++;
                if (n_ovf > 0) after_ovf++;
            end
            if (fld_end) begin
                rec = $sformatf("%s,", rec);
                if (int'(fld_idx) != exp_idx) idx_bad++;
                exp_idx++; n_end++;
                if (n_ovf > 0) after_ovf++;
            end
            if (sent_end) n_sent++;
            if (cks_ok) n_ok++;
            if (cks_bad) n_bad++;
            if (err_abort) n_abort++;
            if (err_ovf) n_ovf++;
            if (err_frame) n_frame++;
            if (sent_end || err_abort || err_ovf || err_frame) exp_idx = 0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_str(input string req, input string exp);
        n_chk++;
        if (rec != exp) begin
            n_fail++;
            $display("FAIL %s: actual \"%s\" expected \"%s\"", req, rec, exp);
        end
    endtask

    task automatic clear();
        clr_req = 1'b1;
        @(negedge clk);
        #1 clr_req = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_hi);
        @(negedge clk) rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx = stop_hi;
        repeat (BIT) @(negedge clk);
        rx = 1'b1;
        if (!stop_hi) repeat (BIT) @(negedge clk);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i], 1'b1);
    endtask

    task automatic settle();
        repeat (4 * BIT) @(negedge clk);
    endtask

    function automatic logic [7:0] xsum(input string s);
        logic [7:0] x = 8'h00;
        for (int i = 1; i < s.len(); i++) begin
            if (s[i] == "*") break;
            x ^= s[i];
        end
        return x;
    endfunction

    function automatic string crlf(input string s);
        return $sformatf("%s%c%c", s, 8'd13, 8'd10);
    endfunction

    task automatic t_reset();
        chk("R12 outputs low after reset",
            int'({fld_valid, fld_end, sent_end, cks_ok, cks_bad, err_abort, err_ovf, err_frame}), 0);
    endtask

    task automatic t_good_cks();
        string b = "$GPGGA,12,,N*";
        clear();
        send_str(crlf($sformatf("%s%02X", b, xsum(b))));
        settle();
        chk_str("R4 R5 field stream", "GPGGA,12,,N,");
        chk("R5 R6 field end count", n_end, 4);
        chk("R4 R5 field index", idx_bad, 0);
        chk("R7 sentence end", n_sent, 1);
        chk("R8 checksum ok", n_ok, 1);
        chk("R8 no bad flag", n_bad, 0);
    endtask

    task automatic t_lower_cks();
        string b = "$zz,k*";
        clear();
        send_str(crlf($sformatf("%s%02x", b, xsum(b))));
        settle();
        chk("R8 lowercase hex ok", n_ok, 1);
    endtask

    task automatic t_bad_cks();
        string b = "$AB,C*";
        clear();
        send_str(crlf($sformatf("%s%02X", b, xsum(b) ^ 8'h01)));
        settle();
        chk("R8 mismatch bad", n_bad, 1);
        chk("R8 mismatch not ok", n_ok, 0);
        clear();
        send_str(crlf("$AB*1"));
        settle();
        chk("R8 single digit bad", n_bad, 1);
        chk("R7 sentence end with short trailer", n_sent, 1);
    endtask

    task automatic t_no_cks();
        clear();
        send_str(crlf("xy$AB,,"));
        settle();
        chk_str("R3 R5 junk ignored empty fields", "AB,,,");
        chk("R6 last field closed by CR", n_end, 3);
        chk("R7 end without trailer", n_sent, 1);
        chk("R8 no flag without star", n_ok + n_bad, 0);
    endtask

    task automatic t_restart();
        clear();
        send_str(crlf("$AB,C$XY,1"));
        settle();
        chk("R9 abort on dollar", n_abort, 1);
        chk_str("R9 restart stream", "AB,CXY,1,");
        chk("R9 index restarts at 0", idx_bad, 0);
        chk("R9 new sentence ends", n_sent, 1);
    endtask

    task automatic t_bad_term();
        clear();
        send_str($sformatf("$A%cZ", 8'd13));
        send_str(crlf("$B"));
        settle();
        chk("R10 abort on bad terminator", n_abort, 1);
        chk("R10 only second sentence ends", n_sent, 1);
        chk_str("R10 char after CR dropped", "A,B,");
    endtask

    task automatic t_frame();
        clear();
        send_str("$AB,");
        send_byte(8'h51, 1'b0);
        send_str(crlf("C"));
        settle();
        chk("R2 framing error flagged", n_frame, 1);
        chk("R2 sentence dropped", n_sent, 0);
        chk_str("R2 no output after error", "AB,");
        clear();
        @(negedge clk) rx = 1'b0;
        repeat (3 * OVS) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        send_str(crlf("$Q"));
        settle();
        chk_str("R1 glitch rejected", "Q,");
        chk("R1 no framing error on glitch", n_frame, 0);
        chk("R1 sentence after glitch", n_sent, 1);
    endtask

    task automatic t_length();
        string s = "$";
        for (int i = 0; i < 79; i++) s = {s, "A"};
        clear();
        send_str(crlf(s));
        settle();
        chk("R11 82 chars accepted", n_sent, 1);
        chk("R11 no overflow at limit", n_ovf, 0);
        s = {s, "AA"};
        clear();
        send_str(crlf(s));
        settle();
        chk("R11 overflow flagged", n_ovf, 1);
        chk("R11 no sentence end", n_sent, 0);
        chk("R11 silent after overflow", after_ovf, 0);
    endtask

    task automatic run_all();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_good_cks();
        t_lower_cks();
        t_bad_cks();
        t_no_cks();
        t_restart();
        t_bad_term();
        t_frame();
        t_length();
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (WD) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule